// File: doc/BRIEF.md
# General-Purpose I/O Port with Per-Pin Direction Control

This block is a small memory-mapped I/O port of up to eight pins. Each pin owns one bit of an output value latch and one bit of a direction register. Software reaches both through a simple synchronous register bus: an address, a write strobe, write data and combinational read data. On the pad side each pin has an input level, an output value and an output enable.

Reading the value register gives, for each pin, the latch bit when the pin is an active output and the synchronized pin level when it is an input. The value latch has no reset, so it keeps its contents across a reset. A separate wakeup or interrupt unit can claim any pin through a per-pin override input. A claimed pin becomes an input whatever its direction bit says. Register bits above the implemented pin count read as zero and cannot be written.

Top module: `gpio_port`

## Requirements
- R1: Reset clears every direction bit, so after reset each `pin_oe` bit is 0 and a read of the direction address (default 1) returns 0.
- R2: Reset leaves the value latch unchanged; `pin_out` shows the same latch contents before and after a reset.
- R3: A write to the value address (default 0) loads the latch whatever the direction bits are, and `pin_out` always presents the latch bits.
- R4: `pin_oe[i]` is 1 only when direction bit i is 1 and `alt_en[i]` is 0. A set override makes the pin an undriven input.
- R5: A read of the value address returns, for bit i, the latch bit when `pin_oe[i]` would be 1. Otherwise it returns the synchronized pin level.
- R6: A pin input level reaches readback through two flops. A level applied before clock edge k appears in read data after edge k+1 and not after edge k.
- R7: A read of the direction address returns the direction bits last written, and a write there loads them.
- R8: Bits at and above `NPINS` in both registers read as 0, and writes to those bits have no effect.
- R9: A read of any address other than the two register addresses returns 0, and a write to such an address changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe, captured on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pin_in | input | NPINS | Pad input levels, asynchronous |
| pin_out | output | NPINS | Pad output values from the latch |
| pin_oe | output | NPINS | Pad output enables |
| alt_en | input | NPINS | Per-pin override from the wakeup/interrupt unit |

## Verification
The bench builds the port with `NPINS` = 6 and `ADDR_W` = 3. With six pins, two reserved bits sit at the top of each register, so the zero readback and the ignored writes can be observed. With three address bits, all six unmapped addresses can be read and written. The bench sweeps all 64 direction patterns against computed latch and pin patterns, and all 64 override patterns with every pin set as an output. It also steps the synchronizer one edge at a time and pulses reset between a latch write and its readback.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int BUS_W = 8;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_VAL  = 2'd1,
        SEL_DIR  = 2'd2
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e           sel;
        logic               wr;
        logic [BUS_W-1:0]   wdata;
    } bus_req_t;

    typedef struct packed {
        logic [BUS_W-1:0] val;
        logic [BUS_W-1:0] dir;
    } port_state_t;

    function automatic logic [BUS_W-1:0] impl_mask(input int npins);
        logic [BUS_W-1:0] m;
        for (int i = 0; i < BUS_W; i++) begin
            m[i] = (i < npins);
        end
        return m;
    endfunction

    function automatic logic [BUS_W-1:0] pick_bits(input logic [BUS_W-1:0] sel_latch,
                                                   input logic [BUS_W-1:0] latch,
                                                   input logic [BUS_W-1:0] pins);
        return (sel_latch & latch) | (~sel_latch & pins);
    endfunction

endpackage

// File: rtl/gpio_decode.sv
module gpio_decode
    import gpio_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int VAL_ADDR = 0,
    parameter int DIR_ADDR = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [BUS_W-1:0]  wdata,
    output bus_req_t          req
);
    localparam logic [ADDR_W-1:0] VAL_A = ADDR_W'(VAL_ADDR);
    localparam logic [ADDR_W-1:0] DIR_A = ADDR_W'(DIR_ADDR);

    always_comb begin
        req.wdata = wdata;
        req.wr    = we;
        if (addr == VAL_A)      req.sel = SEL_VAL;
        else if (addr == DIR_A) req.sel = SEL_DIR;
        else                    req.sel = SEL_NONE;
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  bus_req_t    req,
    output port_state_t state
);
    localparam logic [BUS_W-1:0] MASK = impl_mask(NPINS);

    logic [BUS_W-1:0] val_q;
    logic [BUS_W-1:0] dir_q;
    logic             wr_val;
    logic             wr_dir;

    assign wr_val = req.wr && (req.sel == SEL_VAL);
    assign wr_dir = req.wr && (req.sel == SEL_DIR);

    // value latch: deliberately outside reset
    always_ff @(posedge clk) begin
        if (wr_val) val_q <= req.wdata & MASK;
    end

    always_ff @(posedge clk) begin
        if (rst)         dir_q <= '0;
        else if (wr_dir) dir_q <= req.wdata & MASK;
    end

    assign state.val = val_q & MASK;
    assign state.dir = dir_q & MASK;

    // R7
    dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_dir |=> $stable(state.dir));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_sync
);
    logic [NPINS-1:0] stage1_q;
    logic [NPINS-1:0] stage2_q;
    logic [1:0]       age_q;

    for (genvar i = 0; i < NPINS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1_q[i] <= 1'b0;
                stage2_q[i] <= 1'b0;
            end else begin
                stage1_q[i] <= pin_in[i];
                stage2_q[i] <= stage1_q[i];
            end
        end
    end

    assign pin_sync = stage2_q;

    always_ff @(posedge clk) begin
        if (rst)                 age_q <= '0;
        else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
    end

    // R6
    sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2) |-> (pin_sync == $past(pin_in, 2)));
endmodule

// File: rtl/gpio_readmux.sv
module gpio_readmux
    import gpio_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  reg_sel_e          sel,
    input  port_state_t       state,
    input  logic [NPINS-1:0]  pin_sync,
    input  logic [NPINS-1:0]  alt_en,
    output logic [BUS_W-1:0]  rdata
);
    logic [BUS_W-1:0] pins_w;
    logic [BUS_W-1:0] alt_w;

    always_comb begin
        pins_w = '0;
        alt_w  = '0;
        pins_w[NPINS-1:0] = pin_sync;
        alt_w[NPINS-1:0]  = alt_en;
    end

    always_comb begin
        unique case (sel)
            SEL_VAL:  rdata = pick_bits(state.dir & ~alt_w, state.val, pins_w)
                              & impl_mask(NPINS);
            SEL_DIR:  rdata = state.dir;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int NPINS    = 8,
    parameter int ADDR_W   = 3,
    parameter int VAL_ADDR = 0,
    parameter int DIR_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    input  logic [NPINS-1:0]  alt_en
);
    bus_req_t         req;
    port_state_t      state;
    logic [NPINS-1:0] pin_sync;

    gpio_decode #(.ADDR_W(ADDR_W), .VAL_ADDR(VAL_ADDR), .DIR_ADDR(DIR_ADDR)) u_dec (
        .addr(bus_addr), .we(bus_we), .wdata(bus_wdata), .req(req)
    );

    gpio_regs #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst(rst), .req(req), .state(state)
    );

    gpio_sync #(.NPINS(NPINS)) u_sync (
        .clk(clk), .rst(rst), .pin_in(pin_in), .pin_sync(pin_sync)
    );

    gpio_readmux #(.NPINS(NPINS)) u_mux (
        .sel(req.sel), .state(state), .pin_sync(pin_sync), .alt_en(alt_en),
        .rdata(bus_rdata)
    );

    assign pin_out = state.val[NPINS-1:0];
    assign pin_oe  = state.dir[NPINS-1:0] & ~alt_en;

    // R4
    no_drive_alt_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_oe & alt_en) == '0);

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != ADDR_W'(VAL_ADDR) && bus_addr != ADDR_W'(DIR_ADDR)) |-> (bus_rdata == 8'h00));

    if (NPINS < 8) begin : g_rsvd
        // R8
        rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
            bus_rdata[7:NPINS] == '0);
    end
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
    localparam int NP = 6;
    localparam logic [7:0] M = 8'h3F;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [2:0]      addr = '0;
    logic            we = 1'b0;
    logic [7:0]      wdata = '0;
    logic [7:0]      rdata;
    logic [NP-1:0]   pin_in = '0;
    logic [NP-1:0]   pin_out;
    logic [NP-1:0]   pin_oe;
    logic [NP-1:0]   alt_en = '0;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    gpio_port #(.NPINS(NP), .ADDR_W(3), .VAL_ADDR(0), .DIR_ADDR(1)) u0 (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .alt_en(alt_en)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] l, p, e, eff;
        clks(3);
        rst = 1'b0;
        clks(1);
        // R1 reset state
        chk("R1 oe after reset", {2'b0, pin_oe}, 8'h00);
        rd(3'd1, 8'h00, "R1 dir read after reset");

        // R3 write while input
        wr(3'd0, 8'h2D);
        chk("R3 pin_out after write as input", {2'b0, pin_out}, 8'h2D);
        chk("R3 oe stays low", {2'b0, pin_oe}, 8'h00);
        pin_in = 6'h12;
        clks(2);
        rd(3'd0, 8'h12, "R5 input read shows pins");
        wr(3'd1, 8'h3F);
        rd(3'd0, 8'h2D, "R3 latch captured while input");

        // R5 R7 sweep over all direction patterns
        for (int d = 0; d < 64; d++) begin
            l = 8'((d * 7 + 3)) & M;
            p = 8'((d * 13 + 5)) & M;
            wr(3'd1, 8'(d));
            wr(3'd0, l);
            pin_in = p[NP-1:0];
            clks(2);
            e = ((8'(d) & l) | (~8'(d) & p)) & M;
            rd(3'd0, e, "R5 mixed readback");
            rd(3'd1, 8'(d), "R7 dir readback");
            chk("R4 oe follows dir", {2'b0, pin_oe}, 8'(d));
            chk("R3 pin_out follows latch", {2'b0, pin_out}, l);
        end

        // R4 override sweep
        wr(3'd1, 8'h3F);
        wr(3'd0, 8'h15);
        for (int a = 0; a < 64; a++) begin
            @(negedge clk);
            alt_en = a[NP-1:0];
            pin_in = ~a[NP-1:0];
            clks(2);
            eff = M & ~8'(a);
            e = ((eff & 8'h15) | (~eff & (M & ~8'(a)))) & M;
            chk("R4 oe with override", {2'b0, pin_oe}, eff);
            rd(3'd0, e, "R4 R5 readback with override");
        end
        alt_en = '0;

        // R6 synchronizer depth
        wr(3'd1, 8'h00);
        pin_in = 6'h00;
        clks(3);
        pin_in = 6'h39;
        clks(1);
        rd(3'd0, 8'h00, "R6 not visible after one edge");
        clks(1);
        rd(3'd0, 8'h39, "R6 visible after two edges");

        // R8 reserved bits
        wr(3'd1, 8'hFF);
        rd(3'd1, 8'h3F, "R8 dir reserved bits");
        wr(3'd0, 8'hC0);
        rd(3'd0, 8'h00, "R8 value reserved bits");
        wr(3'd0, 8'hFF);
        rd(3'd0, 8'h3F, "R8 value write all ones");

        // R9 unmapped addresses
        wr(3'd1, 8'h0A);
        wr(3'd0, 8'h21);
        for (int u = 2; u < 8; u++) begin
            wr(3'(u), 8'hFF);
            rd(3'(u), 8'h00, "R9 unmapped read");
        end
        rd(3'd1, 8'h0A, "R9 dir untouched");
        chk("R9 latch untouched", {2'b0, pin_out}, 8'h21);

        // R2 latch survives reset
        wr(3'd0, 8'h2A);
        @(negedge clk);
        rst = 1'b1;
        clks(2);
        rst = 1'b0;
        clks(1);
        chk("R2 pin_out kept through reset", {2'b0, pin_out}, 8'h2A);
        chk("R1 oe cleared by reset", {2'b0, pin_oe}, 8'h00);
        rd(3'd1, 8'h00, "R1 dir cleared by reset");
        wr(3'd1, 8'h3F);
        rd(3'd0, 8'h2A, "R2 latch readback after reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule